// File: doc/BRIEF.md
# Oversampled Serial Receiver with Four-Byte Buffer

This block turns an asynchronous serial line into bytes. Each character has one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Sampling is paced by a single-cycle tick that a separate divider supplies at four times the bit rate. The line first passes through a two-flop synchronizer. A falling edge is then confirmed at the middle of the start bit, and each later bit is taken once, four ticks after the previous sample.

Completed bytes go into a four-entry first-in first-out buffer. The oldest entry is always visible on the data output, and a one-cycle pop strobe removes it. Three status outputs let a register block decide what to do without keeping its own count: empty, full, and a flag for exactly one free slot left. A missing stop bit raises a framing error. A byte that completes while the buffer is full raises an overrun error and is dropped. Both error flags stay set until their own clear strobe arrives.

Top module: `uart4x_rx`

## Requirements
- R1: After reset, `rx_empty` is 1, `rx_full` is 0, `rx_one_left` is 0, and `err_frame` and `err_overrun` are 0.
- R2: A frame on `rxd` (line idle high, a low start bit, eight data bits with bit 0 first, then a stop bit) stores its eight data bits in the buffer. With the buffer previously empty, that byte appears on `rx_data` and `rx_empty` falls.
- R3: The buffer holds up to 4 bytes and returns them in arrival order. `rx_full` is 1 exactly when 4 bytes are stored. A push and a pop in the same cycle leave the stored count unchanged.
- R4: `rx_one_left` is 1 exactly when 3 bytes are stored.
- R5: A byte that completes while `rx_full` is 1 is discarded and sets `err_overrun`. The 4 stored bytes are unchanged.
- R6: A stop bit sampled low sets `err_frame`. The byte is still stored if there is room.
- R7: A low pulse on `rxd` that is high again at the start-bit midpoint (two ticks after the low was first seen) stores nothing and raises no error.
- R8: Each error flag stays 1 until its own clear strobe (`clr_frame` or `clr_overrun`). A clear strobe has no effect on the other flag. A new error in the same cycle as a clear wins.
- R9: A pop while the buffer is empty is ignored: `rx_empty` stays 1 and the next received byte is the first one read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous serial line, idle high |
| os_tick | input | 1 | One-cycle pulse at four times the bit rate |
| pop | input | 1 | Remove the oldest stored byte |
| clr_frame | input | 1 | Clear the framing error flag |
| clr_overrun | input | 1 | Clear the overrun error flag |
| rx_data | output | 8 | Oldest stored byte |
| rx_empty | output | 1 | No bytes stored |
| rx_full | output | 1 | Four bytes stored |
| rx_one_left | output | 1 | Exactly one free slot |
| err_frame | output | 1 | Sticky framing error flag |
| err_overrun | output | 1 | Sticky overrun error flag |

## Verification
The hardest case to reach from the ports is a completed character meeting a full buffer. The internal completion instant cannot be seen, so the stimulus fills all four slots with pops held off, sends a fifth frame, and only then drains the buffer to show that the stored bytes survived. A framing error is produced by driving the stop bit low. That frame is followed at once by a short stretch of low line, so the receiver also has to reject a false start. Random byte bursts of one to four frames, with random line phase against the tick, exercise ordering and the status flags against a queue model kept in the bench.

// File: rtl/uart4x_pkg.sv
package uart4x_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  // Advance a ring pointer that wraps at depth.
  function automatic int unsigned ring_next(input int unsigned p, input int unsigned depth);
    return (p == depth - 1) ? 0 : p + 1;
  endfunction

  // Buffer occupancy after one cycle of push and pop requests.
  function automatic int unsigned level_next(input int unsigned lvl, input logic do_push,
                                             input logic do_pop);
    case ({do_push, do_pop})
      2'b10:   return lvl + 1;
      2'b01:   return lvl - 1;
      default: return lvl;
    endcase
  endfunction

endpackage

// File: rtl/uart4x_sync.sv
module uart4x_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d_async};
  end

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/uart4x_frame.sv
module uart4x_frame
  import uart4x_pkg::*;
#(
  parameter int OSR       = 4,
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line,
  input  logic                 tick,
  output logic                 frame_done,
  output logic                 stop_bad,
  output logic [DATA_BITS-1:0] frame_byte
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(DATA_BITS);
  localparam logic [CW-1:0] MID_CNT  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_BITS - 1);

  rx_state_e            state;
  logic [CW-1:0]        tcnt;
  logic [BW-1:0]        bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 at_mid, at_bit;

  assign at_mid = tick && (tcnt == MID_CNT);
  assign at_bit = tick && (tcnt == LAST_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= RX_IDLE;
      tcnt       <= '0;
      bitn       <= '0;
      shreg      <= '0;
      frame_done <= 1'b0;
      stop_bad   <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (tick && !line) begin
            state <= RX_START;
            tcnt  <= '0;
          end
        end
        RX_START: begin
          if (at_mid) begin
            tcnt  <= '0;
            bitn  <= '0;
            state <= line ? RX_IDLE : RX_DATA;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (at_bit) begin
            tcnt  <= '0;
            shreg <= {line, shreg[DATA_BITS-1:1]};
            if (bitn == LAST_BIT) state <= RX_STOP;
            else                  bitn  <= bitn + 1'b1;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_bit) begin
            tcnt       <= '0;
            frame_done <= 1'b1;
            stop_bad   <= !line;
            state      <= RX_IDLE;
          end else if (tick) begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign frame_byte = shreg;

  // R2
  single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R7
  reject_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && at_mid && line) |=> (state == RX_IDLE && !frame_done));
endmodule

// File: rtl/uart4x_fifo.sv
module uart4x_fifo
  import uart4x_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic             one_left
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    level;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= AW'(ring_next(int'(wr_ptr), DEPTH));
      if (do_pop)  rd_ptr <= AW'(ring_next(int'(rd_ptr), DEPTH));
      level <= LW'(level_next(int'(level), do_push, do_pop));
    end
  end

  assign rdata    = mem[rd_ptr];
  assign empty    = (level == '0);
  assign full     = (level == LW'(DEPTH));
  assign one_left = (level == LW'(DEPTH - 1));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  // R3
  push_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !full) |=> $stable(level));

  // R9
  empty_pop_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> (empty && $stable(rd_ptr)));
endmodule

// File: rtl/uart4x_rx.sv
module uart4x_rx #(
  parameter int OSR       = 4,
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxd,
  input  logic                 os_tick,
  input  logic                 pop,
  input  logic                 clr_frame,
  input  logic                 clr_overrun,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_empty,
  output logic                 rx_full,
  output logic                 rx_one_left,
  output logic                 err_frame,
  output logic                 err_overrun
);
  logic                 line_s;
  logic                 frame_done, stop_bad;
  logic [DATA_BITS-1:0] frame_byte;
  logic                 push_evt, overrun_evt, frame_evt;

  uart4x_sync #(.STAGES(2), .RESET_VAL(1'b1)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (rxd),
    .q_sync  (line_s)
  );

  uart4x_frame #(.OSR(OSR), .DATA_BITS(DATA_BITS)) frame_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .line       (line_s),
    .tick       (os_tick),
    .frame_done (frame_done),
    .stop_bad   (stop_bad),
    .frame_byte (frame_byte)
  );

  assign push_evt    = frame_done && !rx_full;
  assign overrun_evt = frame_done && rx_full;
  assign frame_evt   = frame_done && stop_bad;

  uart4x_fifo #(.WIDTH(DATA_BITS), .DEPTH(DEPTH)) fifo_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_evt),
    .wdata    (frame_byte),
    .pop      (pop),
    .rdata    (rx_data),
    .empty    (rx_empty),
    .full     (rx_full),
    .one_left (rx_one_left)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (frame_evt)        err_frame <= 1'b1;
      else if (clr_frame)   err_frame <= 1'b0;
      if (overrun_evt)      err_overrun <= 1'b1;
      else if (clr_overrun) err_overrun <= 1'b0;
    end
  end

  // R5
  overrun_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> err_overrun);

  // R5
  overrun_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !pop) |=> rx_full);

  // R6
  frame_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_evt |=> err_frame);

  // R8
  sticky_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame && !clr_frame) |=> err_frame);

  // R8
  sticky_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_overrun && !clr_overrun) |=> err_overrun);
endmodule

// File: tb/uart4x_rx_tb.sv
module uart4x_rx_tb_top;
  localparam int BIT_CLKS = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic       pop = 1'b0;
  logic       clr_frame = 1'b0;
  logic       clr_overrun = 1'b0;
  logic [7:0] rx_data;
  logic       rx_empty, rx_full, rx_one_left, err_frame, err_overrun;

  int checks = 0;
  int errors = 0;
  logic [7:0] model[$];
  logic [1:0] div = 2'd0;

  always #4 clk = ~clk;

  always_ff @(posedge clk) begin
    div     <= div + 2'd1;
    os_tick <= (div == 2'd3);
  end

  uart4x_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick), .pop(pop),
    .clr_frame(clr_frame), .clr_overrun(clr_overrun), .rx_data(rx_data),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_one_left(rx_one_left),
    .err_frame(err_frame), .err_overrun(err_overrun)
  );

  function automatic logic exp_full(input int n);     return n == 4; endfunction
  function automatic logic exp_one_left(input int n); return n == 3; endfunction
  function automatic logic exp_empty(input int n);    return n == 0; endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] b, input logic stop_val);
    rxd = 1'b0; idle(BIT_CLKS);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i]; idle(BIT_CLKS);
    end
    rxd = stop_val; idle(BIT_CLKS);
    rxd = 1'b1; idle(6);
  endtask

  task automatic do_pop();
    pop = 1'b1; idle(1);
    pop = 1'b0;
  endtask

  task automatic check_status(input string req);
    check(req, "empty", int'(rx_empty), int'(exp_empty(model.size())));
    check(req, "full", int'(rx_full), int'(exp_full(model.size())));
    check(req, "one_left", int'(rx_one_left), int'(exp_one_left(model.size())));
  endtask

  task automatic drain(input string req);
    while (model.size() > 0) begin
      check(req, "data", int'(rx_data), int'(model[0]));
      void'(model.pop_front());
      do_pop();
      check_status(req);
    end
  endtask

  initial begin
    void'($urandom(32'd5150));
    idle(3);
    rst_n = 1'b1;
    idle(4);
    // R1 reset state
    check("R1", "empty", int'(rx_empty), 1);
    check("R1", "full", int'(rx_full), 0);
    check("R1", "one_left", int'(rx_one_left), 0);
    check("R1", "err_frame", int'(err_frame), 0);
    check("R1", "err_overrun", int'(err_overrun), 0);

    // R9 pop on empty is ignored
    do_pop(); idle(2);
    check("R9", "empty after pop", int'(rx_empty), 1);

    // R2 single byte
    send_frame(8'hA5, 1'b1); model.push_back(8'hA5);
    check("R2", "data", int'(rx_data), 'hA5);
    check_status("R2");
    check("R9", "first byte after empty pop", int'(rx_data), 'hA5);
    drain("R2");

    // R3 R4 fill in order
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b = 8'h11 * 8'(i + 1) ^ 8'h80;
      send_frame(b, 1'b1); model.push_back(b);
      check_status(i == 2 ? "R4" : "R3");
    end

    // R5 overrun on full
    send_frame(8'h3C, 1'b1);
    check("R5", "err_overrun", int'(err_overrun), 1);
    check("R5", "full kept", int'(rx_full), 1);
    check("R6", "no frame err", int'(err_frame), 0);
    drain("R5");

    // R6 framing error, byte still stored; trailing low stretch must not start a frame (R7)
    send_frame(8'h5A, 1'b0); model.push_back(8'h5A);
    idle(40);
    check("R6", "err_frame", int'(err_frame), 1);
    check("R7", "only one byte stored", int'(rx_one_left), 0);
    check_status("R6");
    drain("R6");

    // R8 independent clears
    clr_overrun = 1'b1; idle(1); clr_overrun = 1'b0;
    check("R8", "overrun cleared", int'(err_overrun), 0);
    check("R8", "frame kept", int'(err_frame), 1);
    idle(5);
    check("R8", "frame still sticky", int'(err_frame), 1);
    clr_frame = 1'b1; idle(1); clr_frame = 1'b0;
    check("R8", "frame cleared", int'(err_frame), 0);

    // R7 glitches shorter than half a bit
    for (int g = 0; g < 4; g++) begin
      rxd = 1'b0; idle(3 + g % 2);
      rxd = 1'b1; idle(BIT_CLKS * 12);
    end
    check("R7", "glitch stored nothing", int'(rx_empty), 1);
    check("R7", "glitch no frame err", int'(err_frame), 0);

    // R2 R3 random bursts
    for (int r = 0; r < 8; r++) begin
      int n = 1 + int'($urandom % 4);
      for (int k = 0; k < n; k++) begin
        logic [7:0] b = 8'($urandom);
        idle(int'($urandom % 7));
        send_frame(b, 1'b1); model.push_back(b);
      end
      check_status("R3");
      drain("R2");
    end
    check("R5", "no overrun in bursts", int'(err_overrun), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule